// File: doc/BRIEF.md
# Keyed Watchdog with Reset Pulse

This block is a watchdog timer that software can arm but never disarm. It comes out of reset idle. Writing a fixed two-byte key to its service port, first 1Eh and then E1h, starts a counter that advances once per machine cycle. Each later write of the same key pair restarts the count from zero. If software fails to service it, the counter reaches its ceiling and the block drives a reset pulse of fixed length, measured in oscillator clocks, on its output. The watchdog then returns to its idle state, as the device reset would leave it.

Counting follows the system's low-power status. Power-down always freezes the count. Idle freezes it only when the pause-in-idle control is set. After power-down ends, the count also stays frozen for as long as the wake interrupt line is still held low. A separate control keeps the output from being driven, while the internal overflow and disarm still take place.

The design has two state machines. The main machine has three states. `WD_OFF` is disarmed. `WD_RUN` is armed and counting. `WD_FIRE` drives the pulse. Its transitions are:

- arm: from `WD_OFF` to `WD_RUN` on a completed key.
- overflow: from `WD_RUN` to `WD_FIRE` on the last tick.
- pulse done: from `WD_FIRE` to `WD_OFF` after `PULSE_LEN` clocks.

The key machine has two states, `KS_WAIT` and `KS_HALF`. Its transitions are:

- first byte: from `KS_WAIT` to `KS_HALF` on a 1Eh write.
- complete: from `KS_HALF` to `KS_WAIT` on an E1h write.
- cancel: from `KS_HALF` to `KS_WAIT` on any other byte, except 1Eh, which stays in `KS_HALF`.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed and `rst_pulse` is 0. No pulse ever appears until the watchdog has been armed.
- R2: A write of 1Eh followed by a write of E1h arms the watchdog and starts the count from zero. The E1h must be the next write, but idle clocks between the two writes are allowed.
- R3: While armed, the count advances on each clock where `cyc_en` is 1 and no pause applies. The overflow is the tick that would bring the count to 2^CNT_W-1 (3FFFh by default). That tick comes 2^CNT_W-1 ticks after the last clear. `rst_pulse` rises on the following clock.
- R4: The pulse lasts exactly `PULSE_LEN` clock periods (98 by default).
- R5: An overflow disarms the watchdog. No further pulse comes without a new key.
- R6: A key pair written while armed clears the count, so the next overflow moves out by the full period.
- R7: After 1Eh, a write of any byte other than E1h cancels the key. A repeated 1Eh starts the key again. E1h followed by 1Eh does not complete the key. No write can disarm an armed watchdog.
- R8: In idle the count keeps going when `idle_pause` is 0. When `idle_pause` is 1 it holds, and it resumes when idle ends.
- R9: The count holds on every clock where `pdown` is 1.
- R10: After power-down, the count stays held while `wake_n` is 0. It resumes once `wake_n` is 1.
- R11: With `drive_off` at 1, `rst_pulse` stays 0 through an overflow, and the overflow still disarms the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rst_n | input | 1 | asynchronous active-low hardware reset |
| cyc_en | input | 1 | one-clock strobe per machine cycle |
| wr_en | input | 1 | write strobe for the service port |
| wr_data | input | 8 | byte written to the service port |
| idle | input | 1 | system is in idle |
| idle_pause | input | 1 | 1 freezes the count during idle |
| pdown | input | 1 | system is in power-down |
| wake_n | input | 1 | wake interrupt line, active low |
| drive_off | input | 1 | 1 suppresses the pulse output drive |
| rst_pulse | output | 1 | reset pulse, high for `PULSE_LEN` clocks |

## Verification
The counter, the key state and the wake-hold flag cannot be read, so any fault inside them shows only in when `rst_pulse` rises. A count that drifts, or a pause that leaks, moves the rising edge by exactly the number of clocks gained or lost. That edge arrives at most 2^CNT_W-1 ticks after arming. A key machine that accepts a wrong sequence, or that fails to cancel, either produces a pulse where none is due or drops the pulse that a service should have postponed. The bench compares every rising edge to the cycle predicted from the stimulus, and every pulse width to `PULSE_LEN`.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_t;

    typedef enum logic {
        KS_WAIT = 1'b0,
        KS_HALF = 1'b1
    } key_state_t;
endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
    import kwd_pkg::*;
#(
    parameter int            DW    = 8,
    parameter logic [DW-1:0] KEY_A = 8'h1E,
    parameter logic [DW-1:0] KEY_B = 8'hE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          key_ok
);
    key_state_t st, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= KS_WAIT;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        if (wr_en) begin
            unique case (st)
                KS_WAIT: st_n = (wr_data == KEY_A) ? KS_HALF : KS_WAIT;
                KS_HALF: st_n = (wr_data == KEY_A) ? KS_HALF : KS_WAIT;
                default: st_n = KS_WAIT;
            endcase
        end
    end

    always_comb key_ok = (st == KS_HALF) && wr_en && (wr_data == KEY_B);

    // R7
    key_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == KS_HALF && wr_en && wr_data != KEY_A && wr_data != KEY_B) |=> (st == KS_WAIT));
endmodule

// File: rtl/kwd_tick_gate.sv
module kwd_tick_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic idle,
    input  logic idle_pause,
    input  logic pdown,
    input  logic wake_n,
    output logic tick_ok
);
    logic wake_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wake_hold <= 1'b0;
        else if (pdown)  wake_hold <= 1'b1;
        else if (wake_n) wake_hold <= 1'b0;
    end

    always_comb tick_ok = cyc_en && !pdown && !(wake_hold && !wake_n)
                          && !(idle && idle_pause);

    // R10
    wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdown && wake_n) |=> !wake_hold);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int PULSE_LEN = 98
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       idle,
    input  logic       idle_pause,
    input  logic       pdown,
    input  logic       wake_n,
    input  logic       drive_off,
    output logic       rst_pulse
);
    localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};
    localparam int               PW       = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0]    P_LAST   = PW'(PULSE_LEN - 1);

    logic             key_ok, tick_ok;
    wd_state_t        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [PW-1:0]    pcnt, pcnt_n;

    kwd_key_seq #(.DW(8), .KEY_A(8'h1E), .KEY_B(8'hE1)) u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .key_ok(key_ok)
    );

    kwd_tick_gate u_gate (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .idle(idle),
        .idle_pause(idle_pause), .pdown(pdown), .wake_n(wake_n), .tick_ok(tick_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_OFF;
            cnt   <= '0;
            pcnt  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            pcnt  <= pcnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        pcnt_n  = pcnt;
        unique case (state)
            WD_OFF: begin
                cnt_n = '0;
                if (key_ok) state_n = WD_RUN;
            end
            WD_RUN: begin
                if (key_ok) begin
                    cnt_n = '0;
                end else if (tick_ok) begin
                    if (cnt == CNT_LAST) begin
                        state_n = WD_FIRE;
                        cnt_n   = '0;
                        pcnt_n  = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            WD_FIRE: begin
                if (pcnt == P_LAST) state_n = WD_OFF;
                else                pcnt_n  = pcnt + 1'b1;
            end
            default: state_n = WD_OFF;
        endcase
    end

    always_comb rst_pulse = (state == WD_FIRE) && !drive_off;

    // R3
    paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && !tick_ok && !key_ok) |=> $stable(cnt));
    // R6
    service_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && key_ok) |=> (cnt == '0));
    // R3
    overflow_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && tick_ok && !key_ok && cnt == CNT_LAST) |=> (state == WD_FIRE));
    // R4
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_FIRE && pcnt == P_LAST) |=> (state == WD_OFF));
    // R5
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_FIRE) |=> (state != WD_RUN));
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int PULSE_LEN  = 98;
    localparam int PERIOD     = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b1, wr_en = 1'b0, idle = 1'b0, idle_pause = 1'b0;
    logic       pdown = 1'b0, wake_n = 1'b1, drive_off = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rst_pulse;

    int    cyc = 0, checks = 0, fails = 0, rises = 0, rise_cyc = 0;
    logic  prev_p = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    keyed_watchdog #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_en(wr_en), .wr_data(wr_data),
        .idle(idle), .idle_pause(idle_pause), .pdown(pdown), .wake_n(wake_n),
        .drive_off(drive_off), .rst_pulse(rst_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // monitor: pops expected pulse starts and compares them
    always @(negedge clk) begin
        if (rst_n && rst_pulse && !prev_p) begin
            rises++;
            rise_cyc = cyc;
            if (exp_q.size() == 0) chk(1'b0, "R1/R5/R7/R11 unexpected pulse", cyc, -1);
            else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cyc == e, t, cyc, e);
            end
        end
        if (rst_n && !rst_pulse && prev_p)
            chk(cyc - rise_cyc == PULSE_LEN, "R4 pulse width", cyc - rise_cyc, PULSE_LEN);
        prev_p = rst_pulse;
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic key_pair(output int edge_cyc);
        wr(8'h1E); wr(8'hE1);
        edge_cyc = cyc;
    endtask

    task automatic expect_at(input int at, input string tag);
        exp_q.push_back(at);
        tag_q.push_back(tag);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string tag);
        int r0;
        r0 = rises;
        wait_n(n);
        chk(rises == r0, tag, rises - r0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog timeout actual=%0d expected=0", exp_q.size());
        summary();
    end

    initial begin
        int a, s;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk(rst_pulse == 1'b0, "R1 reset state", rst_pulse, 0);
        quiet(200, "R1 no pulse while disarmed");

        // R2 R3 R4: arm and let it overflow
        key_pair(a);
        expect_at(a + PERIOD, "R2 R3 overflow timing");
        wait_n(PERIOD + PULSE_LEN + 10);
        quiet(200, "R5 disarmed after overflow");

        // R6: service postpones
        key_pair(a);
        wait_n(40);
        key_pair(s);
        expect_at(s + PERIOD, "R6 service clears count");
        wait_n(PERIOD + PULSE_LEN + 10);

        // R7: broken and reversed sequences do not arm
        wr(8'h1E); wr(8'h55); wr(8'hE1);
        quiet(150, "R7 cancelled key does not arm");
        wr(8'hE1); wr(8'h1E);
        quiet(150, "R7 reversed order does not arm");
        wr(8'h00);
        wr(8'h1E); wr(8'h1E); wr(8'hE1);
        expect_at(cyc + PERIOD, "R7 repeated first byte restarts key");
        wait_n(PERIOD + PULSE_LEN + 10);

        // R7: wrong key while armed neither clears nor disarms
        key_pair(a);
        wait_n(20);
        wr(8'h1E); wr(8'h00); wr(8'hE1);
        expect_at(a + PERIOD, "R7 bad key while armed ignored");
        wait_n(PERIOD + PULSE_LEN + 10);

        // R3: cyc_en gating
        key_pair(a);
        cyc_en = 1'b0; wait_n(25); cyc_en = 1'b1;
        expect_at(a + PERIOD + 25, "R3 cyc_en gates ticks");
        wait_n(PERIOD + PULSE_LEN + 10);

        // R8: idle without pause keeps counting
        key_pair(a);
        idle = 1'b1; idle_pause = 1'b0; wait_n(20); idle = 1'b0;
        expect_at(a + PERIOD, "R8 idle counts when pause off");
        wait_n(PERIOD + PULSE_LEN + 10);

        // R8: idle with pause holds
        key_pair(a);
        idle_pause = 1'b1; idle = 1'b1; wait_n(20); idle = 1'b0;
        expect_at(a + PERIOD + 20, "R8 idle holds when pause on");
        wait_n(PERIOD + PULSE_LEN + 30);
        idle_pause = 1'b0;

        // R9: power-down holds
        key_pair(a);
        pdown = 1'b1; wait_n(15); pdown = 1'b0;
        expect_at(a + PERIOD + 15, "R9 power-down holds");
        wait_n(PERIOD + PULSE_LEN + 30);

        // R10: wake line low extends the hold
        key_pair(a);
        wake_n = 1'b0; pdown = 1'b1; wait_n(10); pdown = 1'b0;
        wait_n(7); wake_n = 1'b1;
        expect_at(a + PERIOD + 17, "R10 wake line holds count");
        wait_n(PERIOD + PULSE_LEN + 30);

        // R11: suppressed drive, still disarms
        drive_off = 1'b1;
        key_pair(a);
        quiet(PERIOD + PULSE_LEN + 20, "R11 drive suppressed");
        drive_off = 1'b0;
        quiet(150, "R11 overflow still disarms");

        chk(exp_q.size() == 0, "R3 all expected pulses seen", exp_q.size(), 0);
        summary();
    end
endmodule